// File: doc/BRIEF.md
# Transmit Symbol Selector

This block sits ahead of an 8B/10B encoder and decides, once per byte clock, which symbol the encoder is asked to send. A host or FIFO offers a byte, a control/data select and a violation request. Two active-low load enables let it load the byte at the current clock edge, or announce that the byte present at the following edge should be loaded. This lets the block work with both asynchronous and clocked FIFOs without extra logic. In byte periods when nothing is loaded, the block supplies the K28.5 comma as a fill character on its own.

In encoded mode the block emits a symbol kind and a byte. A violation request beats every other source. In raw mode the encoder is bypassed and a 10-bit word, assembled from the select, the byte and the violation input, is handed to the serializer. An optical-off control gates the enables of serial lanes A and B, while lane C always carries data. Every output is registered, so a selected symbol is presented for the byte period that follows the edge at which it was chosen.

The load control is a two-state machine. WAIT_ST means no deferred load is pending. ARMED_ST means the previous edge saw the next-load enable low. Transitions: WAIT_ST to ARMED_ST when the next-load enable is low. ARMED_ST to WAIT_ST when it is high. Each state holds itself otherwise. An edge loads the inputs when the immediate enable is low or the machine is in ARMED_ST.

Top module: `tx_symbol_sel`

## Requirements
- R1: After reset the outputs are kind FILL (2), byte 0xBC, raw word 0, lane enables 3'b100, and no deferred load is pending.
- R2: When load_now_n is low at a rising edge, din, ctl_sel and viol_req are loaded at that edge, and the resulting symbol appears on the outputs right after that edge, where it stays for one byte period.
- R3: When load_next_n is low at rising edge k, the inputs present at edge k+1 are loaded at edge k+1, even if load_now_n is high there.
- R4: When both enables are low at the same edge, that edge loads its own inputs, and the next edge is also armed to load.
- R5: An edge that loads nothing in encoded mode with viol_req low yields kind FILL (2) with byte 0xBC (K28.5).
- R6: A loaded byte in encoded mode yields kind CTRL (1) when ctl_sel is high and kind DATA (0) when it is low, with sym_byte equal to din.
- R7: In encoded mode a high viol_req at any edge yields kind VIOL (3) with sym_byte 0, whatever the enables, din and ctl_sel are.
- R8: With raw_mode high, kind is RAW (4) and sym_byte is 0. A loading edge gives raw_word = {viol_req, din[7:0], ctl_sel}, bit 0 sent first. A non-loading edge gives the raw comma 10'h17C. In encoded mode raw_word is 0.
- R9: optic_off high at an edge clears the lane A and lane B enables (lane_en[0] and lane_en[1]) for the following byte period. When it is low, both are set.
- R10: The lane C enable (lane_en[2]) is high in every byte period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Byte offered for transmission |
| ctl_sel | input | 1 | High: control code, low: data code |
| viol_req | input | 1 | Violation request; raw bit j in raw mode |
| load_now_n | input | 1 | Active-low load of the current edge's inputs |
| load_next_n | input | 1 | Active-low load of the next edge's inputs |
| raw_mode | input | 1 | High bypasses the encoder |
| optic_off | input | 1 | High disables lanes A and B |
| sym_kind | output | 3 | 0 DATA, 1 CTRL, 2 FILL, 3 VIOL, 4 RAW |
| sym_byte | output | 8 | Byte handed to the encoder |
| raw_word | output | 10 | Unencoded word for the serializer |
| lane_en | output | 3 | Lane enables: bit 0 A, bit 1 B, bit 2 C |

## Verification
On every cycle the assertions check the following: violation priority, fill insertion on idle edges, raw-mode kind, that an armed edge always loads, the optical-off lane gating, and that lane C stays on. The exact load timing cannot be shown by those properties alone: which edge's byte reaches the output under mixed immediate and deferred enables, and the bit placement of the raw word. The bench's sweep covers these by comparing every byte period against an arithmetic model over all enable, select and mode combinations in varied order.

// File: rtl/tx_sel_pkg.sv
package tx_sel_pkg;
    typedef enum logic [2:0] {
        SYM_DATA = 3'd0,
        SYM_CTRL = 3'd1,
        SYM_FILL = 3'd2,
        SYM_VIOL = 3'd3,
        SYM_RAW  = 3'd4
    } sym_kind_e;

    typedef enum logic {
        WAIT_ST  = 1'b0,
        ARMED_ST = 1'b1
    } load_state_e;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam logic [9:0] COMMA_RAW  = 10'h17C;
endpackage

// File: rtl/tx_load_fsm.sv
module tx_load_fsm
    import tx_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_now_n,
    input  logic load_next_n,
    output logic capture
);
    load_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WAIT_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_ST:  if (!load_next_n) state_d = ARMED_ST;
            ARMED_ST: if (load_next_n)  state_d = WAIT_ST;
            default:  state_d = WAIT_ST;
        endcase
    end

    always_comb begin
        capture = !load_now_n || (state_q == ARMED_ST);
    end

    // R3
    armed_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_next_n |=> capture);
endmodule

// File: rtl/tx_symbol_mux.sv
module tx_symbol_mux
    import tx_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int RAW_W = DATA_W + 2
) (
    input  logic              capture,
    input  logic              raw_mode,
    input  logic              viol_req,
    input  logic              ctl_sel,
    input  logic [DATA_W-1:0] din,
    output sym_kind_e         kind,
    output logic [DATA_W-1:0] byte_out,
    output logic [RAW_W-1:0]  raw_out
);
    always_comb begin
        kind     = SYM_FILL;
        byte_out = DATA_W'(COMMA_BYTE);
        raw_out  = '0;
        if (raw_mode) begin
            kind     = SYM_RAW;
            byte_out = '0;
            raw_out  = capture ? {viol_req, din, ctl_sel} : RAW_W'(COMMA_RAW);
        end else if (viol_req) begin
            kind     = SYM_VIOL;
            byte_out = '0;
        end else if (capture) begin
            kind     = ctl_sel ? SYM_CTRL : SYM_DATA;
            byte_out = din;
        end
    end
endmodule

// File: rtl/tx_symbol_sel.sv
module tx_symbol_sel
    import tx_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int RAW_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ctl_sel,
    input  logic              viol_req,
    input  logic              load_now_n,
    input  logic              load_next_n,
    input  logic              raw_mode,
    input  logic              optic_off,
    output logic [2:0]        sym_kind,
    output logic [DATA_W-1:0] sym_byte,
    output logic [RAW_W-1:0]  raw_word,
    output logic [2:0]        lane_en
);
    logic              capture;
    sym_kind_e         kind_d;
    logic [DATA_W-1:0] byte_d;
    logic [RAW_W-1:0]  raw_d;

    tx_load_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_now_n  (load_now_n),
        .load_next_n (load_next_n),
        .capture     (capture)
    );

    tx_symbol_mux #(.DATA_W(DATA_W)) u_mux (
        .capture  (capture),
        .raw_mode (raw_mode),
        .viol_req (viol_req),
        .ctl_sel  (ctl_sel),
        .din      (din),
        .kind     (kind_d),
        .byte_out (byte_d),
        .raw_out  (raw_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_kind <= SYM_FILL;
            sym_byte <= DATA_W'(COMMA_BYTE);
            raw_word <= '0;
            lane_en  <= 3'b100;
        end else begin
            sym_kind <= kind_d;
            sym_byte <= byte_d;
            raw_word <= raw_d;
            lane_en  <= {1'b1, !optic_off, !optic_off};
        end
    end

    // R7
    viol_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_mode && viol_req) |=> (sym_kind == SYM_VIOL && sym_byte == '0));
    // R5
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_mode && !viol_req && !capture) |=> (sym_kind == SYM_FILL));
    // R8
    raw_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |=> (sym_kind == SYM_RAW));
    // R9
    optic_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        optic_off |=> (lane_en[1:0] == 2'b00));
    // R10
    lane_c_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> lane_en[2]);
endmodule

// File: tb/tb_tx_symbol_sel.sv
module tb_tx_symbol_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       ctl_sel = 1'b0, viol_req = 1'b0;
    logic       load_now_n = 1'b1, load_next_n = 1'b1;
    logic       raw_mode = 1'b0, optic_off = 1'b0;
    logic [2:0] sym_kind;
    logic [7:0] sym_byte;
    logic [9:0] raw_word;
    logic [2:0] lane_en;

    int checks = 0, fails = 0;
    logic armed_m;

    always #10 clk = ~clk;

    tx_symbol_sel dut (
        .clk(clk), .rst_n(rst_n), .din(din), .ctl_sel(ctl_sel),
        .viol_req(viol_req), .load_now_n(load_now_n),
        .load_next_n(load_next_n), .raw_mode(raw_mode),
        .optic_off(optic_off), .sym_kind(sym_kind), .sym_byte(sym_byte),
        .raw_word(raw_word), .lane_en(lane_en)
    );

    task automatic check(string req, logic [22:0] act, logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [2:0] ek;
        logic [7:0] eb;
        logic [9:0] er;
        logic [2:0] el;
        logic       cap;
        string      tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values visible before the first active edge
        check("R1", {sym_kind, sym_byte, raw_word, lane_en},
              {3'd2, 8'hBC, 10'h000, 3'b100});
        armed_m = 1'b0;
        for (int i = 0; i < 1536; i++) begin
            logic [4:0] c;
            c = 5'(i) ^ 5'(i >> 5) ^ 5'(i >> 9);
            load_now_n  = c[0];
            load_next_n = c[1];
            viol_req    = c[2] & c[3];
            ctl_sel     = c[3];
            raw_mode    = c[4] & (i[6] | i[8]);
            optic_off   = i[5] ^ i[1];
            din         = 8'(i * 73 + 11);
            cap = !load_now_n || armed_m;
            if (raw_mode) begin
                ek = 3'd4; eb = 8'h00;
                er = cap ? {viol_req, din, ctl_sel} : 10'h17C;
                tag = "R8";
            end else if (viol_req) begin
                ek = 3'd3; eb = 8'h00; er = 10'h000; tag = "R7";
            end else if (!cap) begin
                ek = 3'd2; eb = 8'hBC; er = 10'h000; tag = "R5";
            end else begin
                ek = ctl_sel ? 3'd1 : 3'd0; eb = din; er = 10'h000;
                if (!load_now_n && armed_m) tag = "R4 R6";
                else if (armed_m)           tag = "R3 R6";
                else                        tag = "R2 R6";
            end
            el = {1'b1, !optic_off, !optic_off};
            armed_m = !load_next_n;
            @(negedge clk);
            check(tag, {sym_kind, sym_byte, raw_word, 3'b000},
                  {ek, eb, er, 3'b000});
            check(optic_off ? "R9 R10" : "R10", {20'd0, lane_en}, {20'd0, el});
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule